// File: doc/BRIEF.md
# Microcontroller Clock and Power Mode Sequencer

This block sequences the run and power-down modes of a small microcontroller core. It watches the clock-control fields written by software and moves among three run modes. The first runs from the undivided fast oscillator. The second runs from the slow oscillator. The third runs from a divided copy of the fast oscillator. From each mode it tells the clock tree which source and which divider to use.

When the core signals that it has executed a halt instruction, the block enters a power-down mode. Two control bits decide which one. In the deep mode both the system clock and the time-base clock stop. In the light mode only the system clock stops. In both modes the sub clock keeps running so the watchdog can count. On entry the block emits one-cycle strobes that clear the watchdog, set the power-down flag and clear the watchdog time-out flag. A wake event returns the block to the run mode that was active before the halt.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is asserted and until the first change, `mode` is 0 (fast run), `clk_src` is 1, `clk_div` is 0, `sys_clk_en`, `tb_clk_en` and `sub_clk_en` are 1, and `wdt_clr`, `pd_set` and `to_clr` are 0.
- R2: In a run mode with `hs_sel`=0 and `div_sel` from 2 to 7, `mode` becomes 2 (divided-fast run) after the next clock edge. It shows `clk_src`=1 and `clk_div` equal to the `div_sel` value sampled at that edge.
- R3: In run mode 0 or 2 with `hs_sel`=0 and `div_sel` equal to 0 or 1, `mode` becomes 1 (slow run) after the next edge, with `clk_src`=0 and `clk_div`=0.
- R4: From mode 1, a request for mode 0 or mode 2 takes effect only at an edge where `hs_ready`=1. Until then `mode` stays 1.
- R5: From mode 2, `hs_sel`=1 moves `mode` to 0 after the next edge whatever the value of `hs_ready`.
- R6: A `halt_stb` in a run mode with `idle_en`=0 moves `mode` to 3 (deep sleep) after the next edge. In mode 3, `sys_clk_en`=0, `tb_clk_en`=0 and `sub_clk_en`=1.
- R7: A `halt_stb` in a run mode with `idle_en`=1 and `sys_keep`=0 moves `mode` to 4 (light idle) after the next edge. In mode 4, `sys_clk_en`=0, `tb_clk_en`=1 and `sub_clk_en`=1.
- R8: `wdt_clr`, `pd_set` and `to_clr` are 1 during exactly the first cycle of mode 3 or 4 and are 0 in every other cycle.
- R9: `wake` in mode 3 or 4 returns `mode` to the run mode held before the halt after the next edge, with `sys_clk_en`=1. While powered down and after the wake, `clk_src` and `clk_div` keep their pre-halt values.
- R10: A `halt_stb` with `idle_en`=1 and `sys_keep`=1 does not power the block down. The run-mode rules still apply and no entry strobe is produced.
- R11: A halt in a run mode wins over a clock change requested at the same edge. Control-field changes and `halt_stb` are ignored in mode 3 and 4. `wake` is ignored in a run mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_sel | input | 1 | 1 requests the undivided fast run mode |
| div_sel | input | DIVW | Clock divider field; 0..1 pick slow run, 2..7 pick divided-fast run |
| idle_en | input | 1 | Halt enters light idle (1) or deep sleep (0) |
| sys_keep | input | 1 | With idle_en=1, keeps the system clock; such a halt is not acted on |
| halt_stb | input | 1 | One-cycle pulse: halt instruction executed |
| hs_ready | input | 1 | Fast oscillator stable flag |
| wake | input | 1 | Wake event |
| mode | output | 3 | 0 fast run, 1 slow run, 2 divided-fast run, 3 deep sleep, 4 light idle |
| clk_src | output | 1 | 1 fast oscillator, 0 slow oscillator |
| clk_div | output | DIVW | Divider select for the fast source; 0 when undivided |
| sys_clk_en | output | 1 | System clock enable |
| tb_clk_en | output | 1 | Time-base clock enable |
| sub_clk_en | output | 1 | Sub clock enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| pd_set | output | 1 | Set power-down flag |
| to_clr | output | 1 | Clear time-out flag |

## Verification
The assertions assume that `halt_stb` and `wake` are sampled only at clock edges and that `hs_ready` is a level that may sit low for any number of cycles. They also assume that nothing outside the block forces a mode change. The stimulus applies every input change just after a rising edge and holds it for one full cycle. Each pulse is raised for a single cycle. Halts and wakes are sent into both the modes that act on them and the modes that must ignore them.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int DIVW      = 3,
  parameter int SLOW0_MAX = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hs_sel,
  input  logic [DIVW-1:0] div_sel,
  input  logic            idle_en,
  input  logic            sys_keep,
  input  logic            halt_stb,
  input  logic            hs_ready,
  input  logic            wake,
  output logic [2:0]      mode,
  output logic            clk_src,
  output logic [DIVW-1:0] clk_div,
  output logic            sys_clk_en,
  output logic            tb_clk_en,
  output logic            sub_clk_en,
  output logic            wdt_clr,
  output logic            pd_set,
  output logic            to_clr
);
  localparam logic [2:0] M_NORM  = 3'd0;
  localparam logic [2:0] M_SLOW0 = 3'd1;
  localparam logic [2:0] M_SLOW1 = 3'd2;
  localparam logic [2:0] M_SLEEP = 3'd3;
  localparam logic [2:0] M_IDLE0 = 3'd4;
  localparam logic [DIVW-1:0] S0_TOP = DIVW'(SLOW0_MAX);

  logic [2:0]      mode_q, ret_q;
  logic [DIVW-1:0] div_q;
  logic            entry_q;

  wire       active     = (mode_q == M_NORM) || (mode_q == M_SLOW0) || (mode_q == M_SLOW1);
  wire [2:0] want       = hs_sel ? M_NORM : ((div_sel > S0_TOP) ? M_SLOW1 : M_SLOW0);
  wire       hs_blocked = (mode_q == M_SLOW0) && (want != M_SLOW0) && !hs_ready;
  wire       go_sleep   = active && halt_stb && !idle_en;
  wire       go_idle    = active && halt_stb && idle_en && !sys_keep;
  wire [2:0] run_mode   = active ? mode_q : ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_NORM;
      ret_q   <= M_NORM;
      div_q   <= '0;
      entry_q <= 1'b0;
    end else begin
      entry_q <= 1'b0;
      if (go_sleep || go_idle) begin
        mode_q  <= go_sleep ? M_SLEEP : M_IDLE0;
        ret_q   <= mode_q;
        entry_q <= 1'b1;
      end else if (active) begin
        if (!hs_blocked) begin
          mode_q <= want;
          if (want == M_SLOW1) div_q <= div_sel;
        end
      end else if (wake) begin
        mode_q <= ret_q;
      end
    end
  end

  assign mode       = mode_q;
  assign clk_src    = (run_mode != M_SLOW0);
  assign clk_div    = (run_mode == M_SLOW1) ? div_q : '0;
  assign sys_clk_en = active;
  assign tb_clk_en  = (mode_q != M_SLEEP);
  assign sub_clk_en = 1'b1;
  assign wdt_clr    = entry_q;
  assign pd_set     = entry_q;
  assign to_clr     = entry_q;
endmodule

module pwr_mode_seq_chk #(
  parameter int DIVW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hs_sel,
  input logic [DIVW-1:0] div_sel,
  input logic            idle_en,
  input logic            sys_keep,
  input logic            halt_stb,
  input logic            hs_ready,
  input logic            wake,
  input logic [2:0]      mode,
  input logic            clk_src,
  input logic [DIVW-1:0] clk_div,
  input logic            sys_clk_en,
  input logic            tb_clk_en,
  input logic            sub_clk_en,
  input logic            wdt_clr,
  input logic            pd_set,
  input logic            to_clr
);
  wire run  = (mode <= 3'd2);
  wire down = (mode == 3'd3) || (mode == 3'd4);

  p_slow0_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !hs_ready && !halt_stb) |=> (mode == 3'd1));

  p_slow1_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && hs_sel && !halt_stb) |=> (mode == 3'd0));

  p_halt_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && halt_stb && !idle_en) |=> (mode == 3'd3 && !sys_clk_en && !tb_clk_en && sub_clk_en));

  p_halt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && halt_stb && idle_en && !sys_keep) |=> (mode == 3'd4 && !sys_clk_en && tb_clk_en && sub_clk_en));

  p_entry_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> (down && pd_set && to_clr && $past(run)));

  p_entry_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_clr);

  p_wake_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (down && wake) |=> (run && sys_clk_en));

  p_wake_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (down && wake) |=> ($stable(clk_src) && $stable(clk_div)));

  p_keep_nohalt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && halt_stb && idle_en && sys_keep) |=> (run && !wdt_clr));

  p_down_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (down && !wake) |=> $stable(mode));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.DIVW(DIVW)) u_chk (.*);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIVW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_sel = 1'b1, idle_en = 1'b0, sys_keep = 1'b0, halt_stb = 1'b0, hs_ready = 1'b0, wake = 1'b0;
  logic [DIVW-1:0] div_sel = '0;
  logic [2:0] mode;
  logic clk_src, sys_clk_en, tb_clk_en, sub_clk_en, wdt_clr, pd_set, to_clr;
  logic [DIVW-1:0] clk_div;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [12:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq #(.DIVW(DIVW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hs_sel(hs_sel), .div_sel(div_sel),
    .idle_en(idle_en), .sys_keep(sys_keep), .halt_stb(halt_stb),
    .hs_ready(hs_ready), .wake(wake), .mode(mode), .clk_src(clk_src),
    .clk_div(clk_div), .sys_clk_en(sys_clk_en), .tb_clk_en(tb_clk_en),
    .sub_clk_en(sub_clk_en), .wdt_clr(wdt_clr), .pd_set(pd_set), .to_clr(to_clr)
  );

  wire [12:0] observed = {mode, clk_src, clk_div, sys_clk_en, tb_clk_en, sub_clk_en, wdt_clr, pd_set, to_clr};

  task automatic step(input logic hs, input logic [DIVW-1:0] dv, input logic ien, input logic keep,
                      input logic halt, input logic rdy, input logic wk,
                      input logic [2:0] em, input logic es, input logic [DIVW-1:0] ed,
                      input logic esys, input logic etb, input logic estb, input string tag);
    @(posedge clk);
    #2;
    hs_sel = hs; div_sel = dv; idle_en = ien; sys_keep = keep;
    halt_stb = halt; hs_ready = rdy; wake = wk;
    exp_q.push_back({em, es, ed, esys, etb, 1'b1, estb, estb, estb});
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [12:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (observed !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, observed, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (observed !== 13'b000_1_000_111_000) begin
      fails++;
      $display("FAIL R1 reset: actual %h expected %h", observed, 13'b000_1_000_111_000);
    end
    rst_n = 1'b1;
    //    hs dv ien kp hlt rdy wk   mode src div sys tb stb
    step(1, 0, 0, 0, 0, 0, 0,   3'd0, 1, 3'd0, 1, 1, 0, "R1 stay fast");
    step(0, 5, 0, 0, 0, 0, 0,   3'd2, 1, 3'd5, 1, 1, 0, "R2 div 5");
    step(0, 3, 0, 0, 0, 0, 0,   3'd2, 1, 3'd3, 1, 1, 0, "R2 div 3");
    step(1, 3, 0, 0, 0, 0, 0,   3'd0, 1, 3'd0, 1, 1, 0, "R5 no wait");
    step(0, 1, 0, 0, 0, 0, 0,   3'd1, 0, 3'd0, 1, 1, 0, "R3 slow from fast");
    step(1, 1, 0, 0, 0, 0, 0,   3'd1, 0, 3'd0, 1, 1, 0, "R4 wait 1");
    step(1, 1, 0, 0, 0, 0, 0,   3'd1, 0, 3'd0, 1, 1, 0, "R4 wait 2");
    step(1, 1, 0, 0, 0, 1, 0,   3'd0, 1, 3'd0, 1, 1, 0, "R4 ready");
    step(0, 0, 0, 0, 0, 0, 0,   3'd1, 0, 3'd0, 1, 1, 0, "R3 div 0");
    step(0, 7, 0, 0, 0, 0, 0,   3'd1, 0, 3'd0, 1, 1, 0, "R4 divided wait");
    step(0, 7, 0, 0, 0, 1, 0,   3'd2, 1, 3'd7, 1, 1, 0, "R4 divided ready");
    step(0, 7, 0, 0, 1, 0, 0,   3'd3, 1, 3'd7, 0, 0, 1, "R6 R8 sleep entry");
    step(1, 7, 0, 0, 0, 1, 0,   3'd3, 1, 3'd7, 0, 0, 0, "R8 R11 sleep hold");
    step(0, 7, 0, 0, 1, 0, 0,   3'd3, 1, 3'd7, 0, 0, 0, "R11 halt ignored");
    step(0, 7, 0, 0, 0, 0, 1,   3'd2, 1, 3'd7, 1, 1, 0, "R9 wake to divided");
    step(0, 7, 1, 0, 1, 0, 0,   3'd4, 1, 3'd7, 0, 1, 1, "R7 R8 idle entry");
    step(0, 7, 1, 0, 0, 0, 0,   3'd4, 1, 3'd7, 0, 1, 0, "R8 idle hold");
    step(0, 7, 1, 0, 0, 0, 1,   3'd2, 1, 3'd7, 1, 1, 0, "R9 wake from idle");
    step(0, 7, 1, 1, 1, 0, 0,   3'd2, 1, 3'd7, 1, 1, 0, "R10 kept clock");
    step(0, 0, 0, 0, 0, 0, 0,   3'd1, 0, 3'd0, 1, 1, 0, "R3 slow from divided");
    step(1, 0, 0, 0, 1, 1, 0,   3'd3, 0, 3'd0, 0, 0, 1, "R11 halt beats change");
    step(1, 0, 0, 0, 0, 1, 1,   3'd1, 0, 3'd0, 1, 1, 0, "R9 wake to slow");
    step(1, 0, 0, 0, 0, 1, 0,   3'd0, 1, 3'd0, 1, 1, 0, "R4 ready after wake");
    step(1, 0, 0, 0, 0, 1, 1,   3'd0, 1, 3'd0, 1, 1, 0, "R11 wake ignored");
    step(1, 0, 0, 0, 1, 1, 0,   3'd3, 1, 3'd0, 0, 0, 1, "R6 sleep from fast");
    step(1, 0, 0, 0, 0, 1, 1,   3'd0, 1, 3'd0, 1, 1, 0, "R9 wake to fast");
    step(1, 0, 0, 0, 0, 1, 0,   3'd0, 1, 3'd0, 1, 1, 0, "R8 no strobe");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule